// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents them to a processor through a byte-wide register port with a single address bit. Rising edges on the request lines are held in a pending register, filtered by a mask register, and resolved with a fixed priority in which line 0 wins over every other line. An in-service register records which levels the processor has taken. The interrupt output is raised only when a pending, unmasked level outranks everything already in service, so higher levels can nest over lower ones.

Software sets the block up by writing a start byte to the command address. It follows with up to three bytes on the data address: a vector base, a cascade word (a bitmap of lines carrying a downstream controller when used as a master, or an identity number when used as a downstream controller) and a mode word. Once set up, the data address reads and writes the mask. The command address takes an end-of-interrupt byte, a read-select byte and a poll byte. A poll makes the next command-address read take the winning request and return its number. When nothing is waiting it returns the lowest-priority number with bit 7 of the in-service register left clear, so software can recognise a spurious event.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask is 0xFF, the pending and in-service registers are zero, the interrupt output is low, and a command-address read returns the pending register.
- R2: A command-address write with bit 4 set starts setup. It sets the mask to 0xFF, clears pending and in-service, and selects the pending register for reads. The next data-address writes load, in turn, the vector base, then the cascade word only if bit 1 of the start byte was 0, then the mode word only if bit 0 of the start byte was 1. After the last expected word, data-address writes load the mask again.
- R3: Outside setup, a data-address write loads the mask (bit n set masks line n), and a data-address read returns it.
- R4: A 0-to-1 change on line n sets pending bit n, and a line that stays high sets it only once.
- R5: The interrupt output is high exactly when an unmasked pending level exists whose number is lower than every level in service (or nothing is in service).
- R6: Command byte 0x0C arms a poll. The next command-address read returns 0x80 plus the number of the lowest-numbered unmasked pending line, clears that pending bit and sets the matching in-service bit, even when that line does not outrank the levels in service. The poll is then disarmed.
- R7: A polled read that finds no unmasked pending line returns 0x07 and leaves the in-service register unchanged.
- R8: Command byte 0x20 clears the lowest-numbered set bit of the in-service register.
- R9: Command byte 0x0B selects the in-service register and 0x0A selects the pending register for command-address reads. The choice holds until the next such byte.
- R10: A masked line still records its edge in the pending register, but it neither raises the interrupt output nor is taken by a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| rd_en | input | 1 | Register read strobe; a polled read takes effect at the clock edge |
| addr | input | 1 | 0 selects the command address, 1 the data address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high, zero otherwise |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| vec_base | output | 8 | Stored vector base word |
| casc_cfg | output | 8 | Stored cascade word |
| mode_cfg | output | 8 | Stored mode word |

## Verification
The assertions take for granted that a read strobe and a write strobe are never high in the same cycle. Some of them also take for granted that reset is synchronous and arrives before the first access. They also assume the request lines are synchronous to the clock, so an edge is seen exactly once. The stimulus drives one register access per cycle, never both strobes at once, and changes the request lines only in cycles with no access. A reference model in the bench can therefore replay every edge and every command in order.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_VEC  = 2'd1,
      ST_CASC = 2'd2,
      ST_MODE = 2'd3
   } setup_st_t;

   typedef struct packed {
      logic start_setup;
      logic sel_cmd;
      logic poll_arm;
      logic sel_load;
      logic sel_isr;
      logic eoi;
   } cmd_dec_t;

   localparam int BYTE_W = 8;

   function automatic cmd_dec_t decode_cmd(input logic [BYTE_W-1:0] b);
      cmd_dec_t c;
      c.start_setup = b[4];
      c.sel_cmd     = !b[4] && b[3];
      c.poll_arm    = b[2];
      c.sel_load    = b[1];
      c.sel_isr     = b[0];
      c.eoi         = !b[4] && !b[3] && (b[7:5] == 3'b001);
      return c;
   endfunction

endpackage

// File: rtl/pic8_req_latch.sv
module pic8_req_latch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] irr
);

   for (genvar g = 0; g < N; g++) begin : g_line
      logic prev_q;
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            req_q  <= 1'b0;
         end else begin
            prev_q <= irq_in[g];
            if (clr_all)
               req_q <= 1'b0;
            else if (irq_in[g] && !prev_q)
               req_q <= 1'b1;
            else if (ack_clr[g])
               req_q <= 1'b0;
         end
      end
      assign irr[g] = req_q;
   end

endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic [N-1:0]  vec,
   output logic          hit,
   output logic [LW-1:0] lvl,
   output logic [N-1:0]  onehot
);

   always_comb begin
      hit    = 1'b0;
      lvl    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            hit       = 1'b1;
            lvl       = LW'(i);
            onehot    = '0;
            onehot[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pic8_regs.sv
module pic8_regs
   import pic8_pkg::*;
#(
   parameter int N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [N-1:0]      imr,
   output logic [BYTE_W-1:0] vec_base,
   output logic [BYTE_W-1:0] casc_cfg,
   output logic [BYTE_W-1:0] mode_cfg,
   output logic              sel_isr,
   output logic              poll_armed,
   output logic              setup_pulse,
   output logic              eoi_pulse,
   output logic              st_run
);

   setup_st_t st_q;
   logic      need_casc_q;
   logic      need_mode_q;
   cmd_dec_t  cmd;
   logic      wr_lo;
   logic      wr_hi;
   logic      rd_lo;

   assign cmd         = decode_cmd(wdata);
   assign wr_lo       = wr_en && !addr;
   assign wr_hi       = wr_en && addr;
   assign rd_lo       = rd_en && !addr;
   assign st_run      = (st_q == ST_RUN);
   assign setup_pulse = wr_lo && cmd.start_setup;
   assign eoi_pulse   = wr_lo && st_run && cmd.eoi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_RUN;
         need_casc_q <= 1'b0;
         need_mode_q <= 1'b0;
         imr         <= '1;
         vec_base    <= '0;
         casc_cfg    <= '0;
         mode_cfg    <= '0;
         sel_isr     <= 1'b0;
         poll_armed  <= 1'b0;
      end else if (setup_pulse) begin
         st_q        <= ST_VEC;
         need_casc_q <= !wdata[1];
         need_mode_q <= wdata[0];
         imr         <= '1;
         sel_isr     <= 1'b0;
         poll_armed  <= 1'b0;
      end else begin
         if (wr_hi) begin
            unique case (st_q)
               ST_VEC: begin
                  vec_base <= wdata;
                  st_q     <= need_casc_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_RUN);
               end
               ST_CASC: begin
                  casc_cfg <= wdata;
                  st_q     <= need_mode_q ? ST_MODE : ST_RUN;
               end
               ST_MODE: begin
                  mode_cfg <= wdata;
                  st_q     <= ST_RUN;
               end
               default: imr <= wdata[N-1:0];
            endcase
         end
         if (wr_lo && st_run && cmd.sel_cmd) begin
            if (cmd.poll_arm) poll_armed <= 1'b1;
            if (cmd.sel_load) sel_isr <= cmd.sel_isr;
         end else if (rd_lo) begin
            poll_armed <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
   import pic8_pkg::*;
#(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic               addr,
   input  logic [BYTE_W-1:0]  wdata,
   output logic [BYTE_W-1:0]  rdata,
   input  logic [N_LINES-1:0] irq_in,
   output logic               int_out,
   output logic [BYTE_W-1:0]  vec_base,
   output logic [BYTE_W-1:0]  casc_cfg,
   output logic [BYTE_W-1:0]  mode_cfg
);

   localparam int LVL_W    = (N_LINES > 1) ? $clog2(N_LINES) : 1;
   localparam int SPUR_LVL = N_LINES - 1;

   if (N_LINES < 2 || N_LINES > BYTE_W) begin : g_bad_lines
      $error("pic8_ctrl: N_LINES must lie between 2 and the byte width");
   end

   logic [N_LINES-1:0] irr;
   logic [N_LINES-1:0] isr;
   logic [N_LINES-1:0] imr;
   logic [N_LINES-1:0] pend;
   logic [N_LINES-1:0] p_oh;
   logic [N_LINES-1:0] s_oh;
   logic [N_LINES-1:0] ack_set;
   logic [N_LINES-1:0] eoi_clr;
   logic [LVL_W-1:0]   p_lvl;
   logic [LVL_W-1:0]   s_lvl;
   logic               p_hit;
   logic               s_hit;
   logic               sel_isr;
   logic               poll_armed;
   logic               setup_pulse;
   logic               eoi_pulse;
   logic               st_run;
   logic               poll_rd;

   pic8_regs #(.N(N_LINES)) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .imr         (imr),
      .vec_base    (vec_base),
      .casc_cfg    (casc_cfg),
      .mode_cfg    (mode_cfg),
      .sel_isr     (sel_isr),
      .poll_armed  (poll_armed),
      .setup_pulse (setup_pulse),
      .eoi_pulse   (eoi_pulse),
      .st_run      (st_run)
   );

   pic8_req_latch #(.N(N_LINES)) i_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (setup_pulse),
      .irq_in  (irq_in),
      .ack_clr (ack_set),
      .irr     (irr)
   );

   assign pend = irr & ~imr;

   pic8_prio #(.N(N_LINES), .LW(LVL_W)) i_prio_pend (
      .vec    (pend),
      .hit    (p_hit),
      .lvl    (p_lvl),
      .onehot (p_oh)
   );

   pic8_prio #(.N(N_LINES), .LW(LVL_W)) i_prio_isr (
      .vec    (isr),
      .hit    (s_hit),
      .lvl    (s_lvl),
      .onehot (s_oh)
   );

   assign poll_rd = rd_en && !addr && poll_armed;
   assign ack_set = (poll_rd && p_hit) ? p_oh : '0;
   assign eoi_clr = eoi_pulse ? s_oh : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         isr <= '0;
      else if (setup_pulse)
         isr <= '0;
      else
         isr <= (isr & ~eoi_clr) | ack_set;
   end

   assign int_out = p_hit && (!s_hit || (p_lvl < s_lvl));

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr)
            rdata = BYTE_W'(imr);
         else if (poll_armed)
            rdata = p_hit ? (8'h80 | BYTE_W'(p_lvl)) : BYTE_W'(SPUR_LVL);
         else if (sel_isr)
            rdata = BYTE_W'(isr);
         else
            rdata = BYTE_W'(irr);
      end
   end

endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic         rd_en,
   input logic         addr,
   input logic [7:0]   wdata,
   input logic [N-1:0] irr,
   input logic [N-1:0] isr,
   input logic [N-1:0] imr,
   input logic         poll_armed,
   input logic         st_run,
   input logic         int_out
);

   // R5: the output needs an unmasked pending level behind it
   p_int_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~imr) != '0));

   // R2: setup start leaves mask full and in-service empty
   p_setup_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4]) |=> ((imr == '1) && (isr == '0) && (irr == '0)));

   // R3: the mask moves only on a register write
   p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(imr));

   // R6: a polled read disarms the poll
   p_poll_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr && poll_armed && !wr_en) |=> !poll_armed);

   // R7: a spurious poll leaves in-service untouched
   p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr && poll_armed && ((irr & ~imr) == '0) && !wr_en) |=> $stable(isr));

   // R8: end-of-interrupt removes exactly one in-service bit
   p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && (wdata == 8'h20) && st_run && (isr != '0) && !rd_en)
      |=> ($countones(isr) + 1 == $countones($past(isr))));

endmodule

bind pic8_ctrl pic8_chk #(.N(N_LINES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .irr        (irr),
   .isr        (isr),
   .imr        (imr),
   .poll_armed (poll_armed),
   .st_run     (st_run),
   .int_out    (int_out)
);

// File: tb/test_pic8_ctrl.sv
`timescale 1ns/1ps
module test_pic8_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] irq_in = '0;
   logic       int_out;
   logic [7:0] vec_base;
   logic [7:0] casc_cfg;
   logic [7:0] mode_cfg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   logic [7:0] m_irr = '0, m_isr = '0, m_imr = 8'hFF, m_prev = '0;
   bit m_sel = 0, m_poll = 0, m_need_c = 0, m_need_m = 0;
   int m_st = 0;

   always #4 clk = ~clk;

   pic8_ctrl i_pic8_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
      .vec_base(vec_base), .casc_cfg(casc_cfg), .mode_cfg(mode_cfg)
   );

   function automatic int lowest(input logic [7:0] v);
      int r = 8;
      for (int i = 7; i >= 0; i--) if (v[i]) r = i;
      return r;
   endfunction

   function automatic bit exp_int();
      logic [7:0] p = m_irr & ~m_imr;
      if (p == 0) return 0;
      return lowest(p) < lowest(m_isr);
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 0;
      if (!a) begin
         if (d[4]) begin
            m_imr = 8'hFF; m_irr = 0; m_isr = 0; m_sel = 0; m_poll = 0;
            m_need_c = !d[1]; m_need_m = d[0]; m_st = 1;
         end else if (m_st == 0) begin
            if (d[3]) begin
               if (d[2]) m_poll = 1;
               if (d[1]) m_sel = d[0];
            end else if (d[7:5] == 3'b001 && m_isr != 0) begin
               m_isr[lowest(m_isr)] = 1'b0;
            end
         end
      end else begin
         case (m_st)
            1: m_st = m_need_c ? 2 : (m_need_m ? 3 : 0);
            2: m_st = m_need_m ? 3 : 0;
            3: m_st = 0;
            default: m_imr = d;
         endcase
      end
   endtask

   task automatic rd(input bit a, input string tag);
      logic [7:0] e;
      logic [7:0] p;
      @(negedge clk);
      rd_en = 1; addr = a;
      #1;
      if (a) e = m_imr;
      else if (m_poll) begin
         p = m_irr & ~m_imr;
         if (p != 0) begin
            e = 8'h80 | 8'(lowest(p));
            m_irr[lowest(p)] = 1'b0;
            m_isr[lowest(p)] = 1'b1;
         end else e = 8'h07;
         m_poll = 0;
      end else e = m_sel ? m_isr : m_irr;
      chk(tag, rdata, e);
      @(posedge clk); #1;
      rd_en = 0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(posedge clk); #1;
      m_irr = m_irr | (v & ~m_prev);
      m_prev = v;
   endtask

   task automatic chk_int(input string tag);
      chk(tag, {7'd0, int_out}, {7'd0, exp_int()});
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      void'($urandom(32'h5EED1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk_int("R1 int_out");
      rd(0, "R1 pending after reset");
      rd(1, "R1 mask after reset");

      // R2 full sequence
      wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h04); wr(1, 8'h01);
      chk("R2 vec", vec_base, 8'h00);
      chk("R2 casc", casc_cfg, 8'h04);
      chk("R2 mode", mode_cfg, 8'h01);
      wr(1, 8'hFB);
      rd(1, "R3 mask readback");
      // R2 no cascade word
      wr(0, 8'h13); rd(1, "R2 mask full after start");
      wr(1, 8'h08); wr(1, 8'h01);
      chk("R2 vec skip casc", vec_base, 8'h08);
      chk("R2 casc kept", casc_cfg, 8'h04);
      wr(1, 8'h5A); rd(1, "R2 mask after short setup");
      // R2 vector only
      wr(0, 8'h12); wr(1, 8'h20); wr(1, 8'h00);
      chk("R2 vec only", vec_base, 8'h20);
      rd(1, "R3 mask after vec only");

      // R4 edge latch
      set_irq(8'h08); rd(0, "R4 pending bit 3"); chk_int("R5 single pending");
      set_irq(8'h08); rd(0, "R4 held level once");
      wr(0, 8'h0C); rd(0, "R6 poll level 3"); chk_int("R5 after ack");
      set_irq(8'h28); chk_int("R5 lower level blocked");
      set_irq(8'h2A); chk_int("R5 higher level nests");
      wr(0, 8'h0C); rd(0, "R6 poll level 1");
      wr(0, 8'h0B); rd(0, "R9 in-service read"); rd(0, "R9 selection persists");
      wr(0, 8'h20); rd(0, "R8 eoi clears level 1");
      wr(0, 8'h0C); rd(0, "R6 poll below in-service"); rd(0, "R6 one-shot");
      wr(0, 8'h0C); rd(0, "R7 spurious poll"); rd(0, "R7 in-service unchanged");
      wr(0, 8'h0A); rd(0, "R9 pending selected");
      // R10 masked line
      wr(1, 8'h01); set_irq(8'h00); set_irq(8'h01);
      rd(0, "R10 masked edge recorded"); chk_int("R10 masked no int");
      wr(0, 8'h0C); rd(0, "R10 masked not polled");
      wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'h20);
      wr(0, 8'h0B); rd(0, "R8 in-service emptied");

      // random phase
      for (int it = 0; it < 600; it++) begin
         case ($urandom_range(0, 8))
            0, 1: set_irq(8'($urandom));
            2: wr(1, ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom));
            3: wr(0, 8'h20);
            4: begin wr(0, 8'h0C); rd(0, "R6 random poll"); end
            5: wr(0, $urandom_range(0, 1) ? 8'h0B : 8'h0A);
            6: rd(0, "R9 random low read");
            7: rd(1, "R3 random mask read");
            default: set_irq(8'h00);
         endcase
         chk_int("R5 random int");
      end
      done = 1;
      summary();
   end

endmodule